// File: doc/BRIEF.md
# Multidrop Scan Bridge Address Selector

This block decides whether one scan bridge on a shared test backplane takes part in the current test operation. Every bridge sees the same serial instruction stream. The value shifted into the instruction register is compared at Update-IR with a 6-bit slot address strapped on pins. A bridge can be selected three ways: by its own unique slot code, by the broadcast code, or by one of four multicast group codes that names the group held in its local 2-bit group register.

A selected bridge accepts second-level instructions, latches them for the rest of the bridge, and gates data-register access. It drives the shared serial output only when it was picked by its unique address, so that a broadcast or multicast selection never puts several drivers on the line. An unselected bridge keeps shifting the instruction stream so it can be addressed later. It acts on nothing except the return-to-wait command, and asynchronous test reset also puts it back into the unselected wait state. The TAP controller is outside the block and supplies the shift and update strobes.

Top module: `scan_bridge_selector`

## Requirements
- R1: While `trst_n` is low, and after its release, the bridge is unselected, `l2_instr` is 0, both enables are low and the group register is 0. Reset acts without a clock.
- R2: With `shift_ir` high, each rising `tck` shifts `tdi` into the 8-bit instruction register, LSB first. The register value at an `update_ir` edge is the decoded code.
- R3: In the wait state, a code with bits [7:6] = 00 whose bits [5:0] equal `slot_id`, with the value in 0..58 (0x00–0x3A), selects the bridge in unique mode: `sel`=1, `grp_sel`=0.
- R4: In the wait state, code 0x3B (broadcast) selects every bridge in group mode: `sel`=1, `grp_sel`=1.
- R5: In the wait state, codes 0x3C–0x3F (multicast groups 0–3, group = bits [1:0]) select in group mode only when the group register holds that group.
- R6: A `slot_id` strap of 59 or more can never be selected through the unique address path.
- R7: In the wait state, any other code, including one with nonzero bits [7:6], leaves the bridge unselected. Selection changes only at an `update_ir` edge.
- R8: Code 0xFF (return-to-wait) at `update_ir` deselects the bridge from any state.
- R9: An unselected bridge ignores every other instruction: `l2_instr` and the group register are unchanged.
- R10: A selected bridge latches any instruction other than 0xFF and the group-set form into `l2_instr` at `update_ir`.
- R11: A selected bridge given code 10xxxxgg loads gg into the group register and leaves `l2_instr` unchanged.
- R12: `tdo_en` = unique-mode selected AND (`shift_ir` OR `shift_dr`). `dr_en` = selected AND `shift_dr`.
- R13: A selected bridge does not re-evaluate address codes. It keeps its mode, and such a code is latched as an instruction under R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Backplane test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| slot_id | input | 6 | Strapped slot address |
| shift_ir | input | 1 | TAP is in Shift-IR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_ir | input | 1 | TAP is in Update-IR |
| tdi | input | 1 | Backplane serial data in |
| sel | output | 1 | Bridge is selected |
| grp_sel | output | 1 | Selected through broadcast or multicast |
| tdo_en | output | 1 | Drive enable for the backplane serial output |
| dr_en | output | 1 | Data-register access gate |
| l2_instr | output | 8 | Last accepted second-level instruction |

## Verification
The hardest state to reach from the ports is a changed group register seen only through later multicast selection. It can only be loaded while the bridge is selected, and it has no output of its own. The stimulus first selects by broadcast, sends the group-set form, returns to wait, and then probes each multicast code. The same path is repeated with the bridge unselected to show that the register did not move.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   typedef enum logic [1:0] {
      SEL_WAIT  = 2'd0,
      SEL_UNIQ  = 2'd1,
      SEL_GROUP = 2'd2
   } sel_state_t;
endpackage

// File: rtl/sbr_ir_shift.sv
module sbr_ir_shift #(
   parameter int IR_W = 8
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            shift_en,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_sh
);
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         ir_sh <= '0;
      else if (shift_en)
         ir_sh <= {tdi, ir_sh[IR_W-1:1]};
   end
endmodule

// File: rtl/sbr_addr_match.sv
module sbr_addr_match #(
   parameter int ADDR_W = 6,
   parameter int IR_W   = 8,
   parameter int GRP_W  = 2
) (
   input  logic [IR_W-1:0]   ir_sh,
   input  logic [ADDR_W-1:0] slot_id,
   input  logic [GRP_W-1:0]  grp_q,
   output logic              hit_uniq,
   output logic              hit_group,
   output logic              is_wait,
   output logic              is_setgrp
);
   localparam int NUM_CODES = 1 << ADDR_W;
   localparam int NUM_GRP   = 1 << GRP_W;
   localparam int MC_BASE   = NUM_CODES - NUM_GRP;
   localparam int BC_CODE   = MC_BASE - 1;

   logic [ADDR_W-1:0] code;
   logic              addr_form;
   logic              bc_hit;
   logic              mc_hit;

   always_comb begin
      code      = ir_sh[ADDR_W-1:0];
      addr_form = (ir_sh[IR_W-1:ADDR_W] == '0);
      is_wait   = &ir_sh;
      is_setgrp = (ir_sh[IR_W-1 -: 2] == 2'b10);
      bc_hit    = (code == ADDR_W'(BC_CODE));
      mc_hit    = (code >= ADDR_W'(MC_BASE)) && (code[GRP_W-1:0] == grp_q);
      hit_uniq  = addr_form && (code < ADDR_W'(BC_CODE)) && (code == slot_id);
      hit_group = addr_form && (bc_hit || mc_hit);
   end
endmodule

// File: rtl/sbr_sel_ctrl.sv
module sbr_sel_ctrl
   import sbr_pkg::*;
#(
   parameter int IR_W     = 8,
   parameter int GRP_W    = 2,
   parameter bit GROUP_EN = 1'b1
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             update_ir,
   input  logic [IR_W-1:0]  ir_sh,
   input  logic             hit_uniq,
   input  logic             hit_group,
   input  logic             is_wait,
   input  logic             is_setgrp,
   output sel_state_t       state,
   output logic [GRP_W-1:0] grp_q,
   output logic [IR_W-1:0]  l2_instr
);
   logic selected;
   assign selected = (state != SEL_WAIT);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         state <= SEL_WAIT;
      else if (update_ir) begin
         if (is_wait)
            state <= SEL_WAIT;
         else if (!selected) begin
            if (hit_uniq)
               state <= SEL_UNIQ;
            else if (hit_group)
               state <= SEL_GROUP;
         end
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         l2_instr <= '0;
      else if (update_ir && selected && !is_wait && !is_setgrp)
         l2_instr <= ir_sh;
   end

   generate
      if (GROUP_EN) begin : g_grp
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)
               grp_q <= '0;
            else if (update_ir && selected && is_setgrp)
               grp_q <= ir_sh[GRP_W-1:0];
         end
      end else begin : g_nogrp
         assign grp_q = '0;
      end
   endgenerate
endmodule

// File: rtl/scan_bridge_selector.sv
module scan_bridge_selector
   import sbr_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int IR_W     = 8,
   parameter int GRP_W    = 2,
   parameter bit GROUP_EN = 1'b1
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic [ADDR_W-1:0] slot_id,
   input  logic              shift_ir,
   input  logic              shift_dr,
   input  logic              update_ir,
   input  logic              tdi,
   output logic              sel,
   output logic              grp_sel,
   output logic              tdo_en,
   output logic              dr_en,
   output logic [IR_W-1:0]   l2_instr
);
   generate
      if (IR_W < ADDR_W + 2) begin : g_bad_ir
         $error("IR_W must leave two opcode bits above the address");
      end
      if (GRP_W >= ADDR_W) begin : g_bad_grp
         $error("GRP_W must be narrower than ADDR_W");
      end
   endgenerate

   logic [IR_W-1:0]  ir_sh;
   logic [GRP_W-1:0] grp_q;
   logic             hit_uniq;
   logic             hit_group;
   logic             is_wait;
   logic             is_setgrp;
   sel_state_t       state;

   sbr_ir_shift #(.IR_W(IR_W)) u_ir (
      .tck      (tck),
      .trst_n   (trst_n),
      .shift_en (shift_ir),
      .tdi      (tdi),
      .ir_sh    (ir_sh)
   );

   sbr_addr_match #(.ADDR_W(ADDR_W), .IR_W(IR_W), .GRP_W(GRP_W)) u_match (
      .ir_sh     (ir_sh),
      .slot_id   (slot_id),
      .grp_q     (grp_q),
      .hit_uniq  (hit_uniq),
      .hit_group (hit_group),
      .is_wait   (is_wait),
      .is_setgrp (is_setgrp)
   );

   sbr_sel_ctrl #(.IR_W(IR_W), .GRP_W(GRP_W), .GROUP_EN(GROUP_EN)) u_ctrl (
      .tck       (tck),
      .trst_n    (trst_n),
      .update_ir (update_ir),
      .ir_sh     (ir_sh),
      .hit_uniq  (hit_uniq),
      .hit_group (hit_group),
      .is_wait   (is_wait),
      .is_setgrp (is_setgrp),
      .state     (state),
      .grp_q     (grp_q),
      .l2_instr  (l2_instr)
   );

   always_comb begin
      sel     = (state != SEL_WAIT);
      grp_sel = (state == SEL_GROUP);
      tdo_en  = (state == SEL_UNIQ) && (shift_ir || shift_dr);
      dr_en   = sel && shift_dr;
   end
endmodule

// File: rtl/scan_bridge_selector_chk.sv
module scan_bridge_selector_chk #(
   parameter int IR_W  = 8,
   parameter int GRP_W = 2
) (
   input logic             tck,
   input logic             trst_n,
   input logic             update_ir,
   input logic [IR_W-1:0]  ir_sh,
   input logic [GRP_W-1:0] grp_q,
   input logic             sel,
   input logic             grp_sel,
   input logic             tdo_en,
   input logic             dr_en,
   input logic [IR_W-1:0]  l2_instr
);
   a_r12_tdo_uniq_only: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (sel && !grp_sel));

   a_r12_dr_gate: assert property (@(posedge tck) disable iff (!trst_n)
      dr_en |-> sel);

   a_r8_wait_cmd: assert property (@(posedge tck) disable iff (!trst_n)
      (update_ir && (&ir_sh)) |=> !sel);

   a_r7_sel_needs_update: assert property (@(posedge tck) disable iff (!trst_n)
      (!sel && !update_ir) |=> !sel);

   a_r9_instr_hold: assert property (@(posedge tck) disable iff (!trst_n)
      !sel |=> $stable(l2_instr));

   a_r9_group_hold: assert property (@(posedge tck) disable iff (!trst_n)
      !sel |=> $stable(grp_q));

   a_r13_mode_kept: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && !grp_sel && !(update_ir && (&ir_sh))) |=> (sel && !grp_sel));
endmodule

bind scan_bridge_selector scan_bridge_selector_chk #(.IR_W(IR_W), .GRP_W(GRP_W)) u_chk (
   .tck       (tck),
   .trst_n    (trst_n),
   .update_ir (update_ir),
   .ir_sh     (ir_sh),
   .grp_q     (grp_q),
   .sel       (sel),
   .grp_sel   (grp_sel),
   .tdo_en    (tdo_en),
   .dr_en     (dr_en),
   .l2_instr  (l2_instr)
);

// File: tb/scan_bridge_selector_tb.sv
module scan_bridge_selector_tb;
   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic [5:0] slot_id = '0;
   logic       shift_ir = 1'b0;
   logic       shift_dr = 1'b0;
   logic       update_ir = 1'b0;
   logic       tdi = 1'b0;
   logic       sel, grp_sel, tdo_en, dr_en;
   logic [7:0] l2_instr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 tck = ~tck;

   scan_bridge_selector u_dut (
      .tck(tck), .trst_n(trst_n), .slot_id(slot_id), .shift_ir(shift_ir),
      .shift_dr(shift_dr), .update_ir(update_ir), .tdi(tdi), .sel(sel),
      .grp_sel(grp_sel), .tdo_en(tdo_en), .dr_en(dr_en), .l2_instr(l2_instr)
   );

   // {slot[5:0], code[7:0], exp_sel, exp_grp}
   localparam logic [15:0] VEC [10] = '{
      {6'd5,  8'h05, 1'b1, 1'b0},  // R3
      {6'd5,  8'h06, 1'b0, 1'b0},  // R7
      {6'd0,  8'h00, 1'b1, 1'b0},  // R3
      {6'd58, 8'h3A, 1'b1, 1'b0},  // R3
      {6'd59, 8'h3B, 1'b1, 1'b1},  // R4
      {6'd59, 8'h3A, 1'b0, 1'b0},  // R7
      {6'd62, 8'h3E, 1'b0, 1'b0},  // R5 R6
      {6'd7,  8'h3C, 1'b1, 1'b1},  // R5
      {6'd5,  8'h45, 1'b0, 1'b0},  // R7
      {6'd12, 8'h3B, 1'b1, 1'b1}   // R4
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_ir(input logic [7:0] code);
      for (int i = 0; i < 8; i++) begin
         @(negedge tck);
         shift_ir = 1'b1;
         tdi = code[i];
      end
      @(negedge tck);
      shift_ir = 1'b0;
      update_ir = 1'b1;
      @(negedge tck);
      update_ir = 1'b0;
      #1;
   endtask

   task automatic probe_dr(output logic t_en, output logic d_en);
      @(negedge tck);
      shift_dr = 1'b1;
      #1;
      t_en = tdo_en;
      d_en = dr_en;
      @(negedge tck);
      shift_dr = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic t, d;
      repeat (3) @(negedge tck);
      #1;
      check("R1 sel in reset", sel, 0);
      check("R1 l2 in reset", l2_instr, 0);
      check("R1 enables in reset", {tdo_en, dr_en}, 0);
      trst_n = 1'b1;

      for (int v = 0; v < 10; v++) begin
         send_ir(8'hFF);
         slot_id = VEC[v][15:10];
         send_ir(VEC[v][9:2]);
         check($sformatf("R2 R3 R4 R5 R6 R7 vec%0d sel", v), sel, VEC[v][1]);
         check($sformatf("R3 R4 R5 vec%0d grp_sel", v), grp_sel, VEC[v][0]);
      end

      // R12 enables in unique and group modes
      send_ir(8'hFF);
      slot_id = 6'd9;
      send_ir(8'h09);
      probe_dr(t, d);
      check("R12 tdo_en unique shift_dr", t, 1);
      check("R12 dr_en unique shift_dr", d, 1);
      check("R12 tdo_en idle", tdo_en, 0);
      // R13 broadcast code while uniquely selected is an instruction
      send_ir(8'h3B);
      check("R13 mode kept", {sel, grp_sel}, 2'b10);
      check("R10 R13 l2 latched", l2_instr, 8'h3B);
      send_ir(8'hFF);
      check("R8 wait from unique", sel, 0);
      send_ir(8'h3B);
      probe_dr(t, d);
      check("R12 tdo_en group mode", t, 0);
      check("R12 dr_en group mode", d, 1);

      // R11 set group 2 while selected
      send_ir(8'h82);
      check("R11 l2 unchanged by setgrp", l2_instr, 8'h3B);
      send_ir(8'h5A);
      check("R10 l2 latched", l2_instr, 8'h5A);
      send_ir(8'hFF);
      check("R8 wait from group", sel, 0);
      send_ir(8'h3C);
      check("R11 old group 0 misses", sel, 0);
      send_ir(8'h3E);
      check("R11 group 2 hits", {sel, grp_sel}, 2'b11);
      send_ir(8'hFF);

      // R9 unselected ignores setgrp and others
      send_ir(8'h83);
      send_ir(8'h55);
      check("R9 l2 unchanged", l2_instr, 8'h5A);
      check("R9 still unselected", sel, 0);
      send_ir(8'h3F);
      check("R9 group 3 not loaded", sel, 0);
      send_ir(8'h3E);
      check("R9 group still 2", sel, 1);

      // R1 asynchronous reset mid-cycle
      @(negedge tck);
      #2;
      trst_n = 1'b0;
      #1;
      check("R1 async deselect", sel, 0);
      check("R1 async l2 clear", l2_instr, 0);
      @(negedge tck);
      trst_n = 1'b1;
      send_ir(8'h3C);
      check("R1 group reset to 0", {sel, grp_sel}, 2'b11);
      finish_run();
   end
endmodule